// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor. The distributor presents its best pending candidate: an ID, the number of the CPU that raised it (for software interrupts), and an 8-bit priority where a lower value is more urgent. The block drives `irq_o` when that candidate beats both a programmable priority mask and the processor's current running priority.

Software reads an acknowledge register to take the interrupt. This read has a side effect. It returns the source and the ID, pulses an activate strobe toward the distributor, and raises the running priority to the candidate's level. Software writes the ID back to an end-of-interrupt register when it is done. That pulses a retire strobe and restores the running priority that was in force before the acknowledge.

Nesting is held on a small stack of saved running priorities. When nothing qualifies, the reserved ID 1023 means spurious. Register access is single-cycle: read data is combinational from the address, and all state changes at the next rising clock edge.

Top module: `cpuif_ack_unit`

## Requirements
- R1: After reset the enable bit is 0, the priority mask is 0x00, the running priority is 0xFF (idle) and `irq_o` is low.
- R2: `irq_o` is high exactly when all of these hold: the enable bit is set, a candidate is valid, the candidate priority is numerically below the mask, the candidate priority is numerically below the running priority, and the nesting stack is not full. A priority equal to the mask or to the running priority does not qualify.
- R3: A read of offset 0x0C while `irq_o` would be high returns the candidate ID in bits 9:0 and the source CPU in bits 12:10, with every other bit zero. In the same cycle it pulses `act_vld_o` with `act_id_o` equal to the ID. From the next cycle the running priority equals the candidate's priority.
- R4: A read of offset 0x0C with no qualifying candidate returns 1023 (0x3FF) and does not pulse `act_vld_o`. The running priority is left unchanged.
- R5: `irq_o` is low in any cycle in which offset 0x0C is being read.
- R6: A write to offset 0x10 while at least one interrupt is active pulses `eoi_vld_o` in that cycle, with `eoi_id_o` equal to write data bits 9:0. It restores the running priority saved by the matching acknowledge, so nested acknowledges unwind in reverse order back to 0xFF.
- R7: A write to offset 0x10 is ignored when no interrupt is active or when the written ID is 1023. In that case no `eoi_vld_o` pulse occurs and the running priority is unchanged.
- R8: The stack holds `STACK_DEPTH` (default 4) nested priorities. While it is full, no candidate is signalled and an acknowledge read returns 1023.
- R9: Reads return the following: offset 0x00 gives the enable bit in bit 0; 0x04 gives the mask in bits 7:0; 0x14 gives the running priority in bits 7:0. Offset 0x18 gives the candidate's ID and source word, laid out as in R3, whenever a candidate is valid, whatever the mask and priority. When no candidate is valid it gives 1023. Other offsets read 0.
- R10: Writes to offset 0x00 (bit 0 is the enable) and to offset 0x04 (bits 7:0 are the mask) take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Distributor has a pending candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_src_i | input | 3 | Requesting CPU of the candidate |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request to the CPU |
| act_vld_o | output | 1 | Acknowledge taken: activate this ID |
| act_id_o | output | 10 | ID being activated |
| eoi_vld_o | output | 1 | End of interrupt: retire this ID |
| eoi_id_o | output | 10 | ID being retired |

## Verification
The candidate priority is moved through values below, equal to and above both the mask and the running priority. This separates the strict comparisons from inclusive ones and confirms that either threshold alone can block signalling. Acknowledges are tried with and without a qualifying candidate, which separates the activate path from the spurious 1023 return. Nested acknowledges followed by end-of-interrupt writes in reverse order show that each retirement restores the right saved priority. Filling the stack and writing end-of-interrupt on an empty stack, or with ID 1023, exercise the boundaries where state must not move.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned SRC_W  = 3;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ID_W-1:0]   ID_SPURIOUS = 10'd1023;
  localparam logic [PRIO_W-1:0] PRIO_IDLE   = '1;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_ACK  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_EOI  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RUN  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_HIGH = 8'h18;

  function automatic logic [DATA_W-1:0] id_word(logic [SRC_W-1:0] src, logic [ID_W-1:0] id);
    return {{(DATA_W-SRC_W-ID_W){1'b0}}, src, id};
  endfunction
endpackage

// File: rtl/cpuif_gate.sv
module cpuif_gate #(
  parameter int unsigned PW = 8
) (
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [PW-1:0] prio_i,
  input  logic [PW-1:0] mask_i,
  input  logic [PW-1:0] run_i,
  input  logic          full_i,
  output logic          hit_o
);
  // strict compares: equal priority never preempts
  assign hit_o = en_i & valid_i & (prio_i < mask_i) & (prio_i < run_i) & ~full_i;
endmodule

// File: rtl/cpuif_prio_stack.sv
module cpuif_prio_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [PW-1:0]                push_val_i,
  output logic [PW-1:0]                top_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o,
  output logic                         full_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] wr_idx, top_idx;

  assign wr_idx  = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign depth_o = cnt_q;
  assign top_o   = (cnt_q == '0) ? '1 : mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (push_i && !full_o) begin
      mem_q[wr_idx] <= push_val_i;
      cnt_q         <= cnt_q + CW'(1);
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/cpuif_ack_unit.sv
module cpuif_ack_unit
  import cpuif_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [SRC_W-1:0]  cand_src_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              act_vld_o,
  output logic [ID_W-1:0]   act_id_o,
  output logic              eoi_vld_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam int unsigned CW = $clog2(STACK_DEPTH+1);

  logic              en_q;
  logic [PRIO_W-1:0] pmask_q, run_q, stk_top;
  logic [CW-1:0]     stk_depth;
  logic              stk_full, hit;
  logic              ack_rd, eoi_wr, take, retire;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:ID_W];

  cpuif_gate #(.PW(PRIO_W)) gate_i (
    .en_i(en_q), .valid_i(cand_valid_i), .prio_i(cand_prio_i),
    .mask_i(pmask_q), .run_i(run_q), .full_i(stk_full), .hit_o(hit)
  );

  assign ack_rd = reg_sel_i & ~reg_wr_i & (reg_addr_i == OFF_ACK);
  assign eoi_wr = reg_sel_i &  reg_wr_i & (reg_addr_i == OFF_EOI);
  assign take   = ack_rd & hit;
  assign retire = eoi_wr & (stk_depth != '0) & (reg_wdata_i[ID_W-1:0] != ID_SPURIOUS);

  cpuif_prio_stack #(.DEPTH(STACK_DEPTH), .PW(PRIO_W)) stack_i (
    .clk_i, .rst_ni,
    .push_i(take), .pop_i(retire), .push_val_i(run_q),
    .top_o(stk_top), .depth_o(stk_depth), .full_o(stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pmask_q <= '0;
      run_q   <= PRIO_IDLE;
    end else begin
      if (reg_sel_i && reg_wr_i && reg_addr_i == OFF_CTRL) en_q    <= reg_wdata_i[0];
      if (reg_sel_i && reg_wr_i && reg_addr_i == OFF_MASK) pmask_q <= reg_wdata_i[PRIO_W-1:0];
      if (take)        run_q <= cand_prio_i;
      else if (retire) run_q <= stk_top;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFF_CTRL: reg_rdata_o = {{(DATA_W-1){1'b0}}, en_q};
      OFF_MASK: reg_rdata_o = {{(DATA_W-PRIO_W){1'b0}}, pmask_q};
      OFF_ACK:  reg_rdata_o = hit ? id_word(cand_src_i, cand_id_i) : DATA_W'(ID_SPURIOUS);
      OFF_RUN:  reg_rdata_o = {{(DATA_W-PRIO_W){1'b0}}, run_q};
      OFF_HIGH: reg_rdata_o = cand_valid_i ? id_word(cand_src_i, cand_id_i) : DATA_W'(ID_SPURIOUS);
      default:  reg_rdata_o = '0;
    endcase
  end

  // drop request while the acknowledge is in flight
  assign irq_o     = hit & ~ack_rd;
  assign act_vld_o = take;
  assign act_id_o  = cand_id_i;
  assign eoi_vld_o = retire;
  assign eoi_id_o  = reg_wdata_i[ID_W-1:0];
endmodule

// File: rtl/cpuif_ack_chk.sv
module cpuif_ack_chk
  import cpuif_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 4
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             irq_o,
  input logic                             ack_rd,
  input logic                             en_q,
  input logic [PRIO_W-1:0]                pmask_q,
  input logic [PRIO_W-1:0]                run_q,
  input logic                             cand_valid_i,
  input logic [PRIO_W-1:0]                cand_prio_i,
  input logic                             act_vld_o,
  input logic                             eoi_vld_o,
  input logic [$clog2(STACK_DEPTH+1)-1:0] stk_depth
);
  p_irq_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q && cand_valid_i && cand_prio_i < pmask_q && cand_prio_i < run_q));

  p_irq_low_on_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd |-> !irq_o);

  p_run_after_act_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_vld_o |=> run_q == $past(cand_prio_i));

  p_eoi_needs_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_vld_o |-> stk_depth != '0);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_depth <= ($clog2(STACK_DEPTH+1))'(STACK_DEPTH));

  p_idle_when_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_depth == '0 |-> run_q == PRIO_IDLE);

  p_run_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_vld_o && !eoi_vld_o) |=> $stable(run_q));
endmodule

bind cpuif_ack_unit cpuif_ack_chk #(.STACK_DEPTH(STACK_DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .ack_rd(ack_rd),
  .en_q(en_q), .pmask_q(pmask_q), .run_q(run_q),
  .cand_valid_i(cand_valid_i), .cand_prio_i(cand_prio_i),
  .act_vld_o(act_vld_o), .eoi_vld_o(eoi_vld_o), .stk_depth(stk_depth)
);

// File: tb/cpuif_ack_unit_tb.sv
module cpuif_ack_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cand_valid_i = 1'b0;
  logic [9:0]  cand_id_i = '0;
  logic [2:0]  cand_src_i = '0;
  logic [7:0]  cand_prio_i = '0;
  logic        reg_sel_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, act_vld_o, eoi_vld_o;
  logic [9:0]  act_id_o, eoi_id_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cpuif_ack_unit dut_i (.*);

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cand(bit v, int id, int src, int prio);
    @(negedge clk_i);
    cand_valid_i = v; cand_id_i = 10'(id); cand_src_i = 3'(src); cand_prio_i = 8'(prio);
    #1;
  endtask

  // one read cycle; captures combinational outputs before the edge
  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic av,
                    output logic [9:0] aid, output logic irq);
    @(negedge clk_i);
    reg_sel_i = 1; reg_wr_i = 0; reg_addr_i = a;
    #1;
    d = reg_rdata_o; av = act_vld_o; aid = act_id_o; irq = irq_o;
    @(posedge clk_i); #1;
    reg_sel_i = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic ev,
                    output logic [9:0] eid);
    @(negedge clk_i);
    reg_sel_i = 1; reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    #1;
    ev = eoi_vld_o; eid = eoi_id_o;
    @(posedge clk_i); #1;
    reg_sel_i = 0; reg_wr_i = 0;
  endtask

  function automatic logic [31:0] word(int src, int id);
    return 32'((src << 10) | id);
  endfunction

  task automatic t_reset;
    logic [31:0] d; logic av, irq; logic [9:0] aid;
    rd(8'h00, d, av, aid, irq); chk("R1 ctrl", d, 0);
    rd(8'h04, d, av, aid, irq); chk("R1 mask", d, 0);
    rd(8'h14, d, av, aid, irq); chk("R1 run", d, 32'hFF);
    chk("R1 irq", irq_o, 0);
    rd(8'h0C, d, av, aid, irq); chk("R4 ack empty", d, 1023); chk("R4 no act", av, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d; logic av, irq, ev; logic [9:0] aid, eid;
    wr(8'h00, 32'h1, ev, eid);
    wr(8'h04, 32'hF0, ev, eid);
    rd(8'h00, d, av, aid, irq); chk("R10 ctrl", d, 1);
    rd(8'h04, d, av, aid, irq); chk("R10 mask", d, 32'hF0);
    rd(8'h20, d, av, aid, irq); chk("R9 other", d, 0);
    set_cand(1, 45, 2, 8'hFE);
    rd(8'h18, d, av, aid, irq); chk("R9 highest", d, word(2, 45));
    set_cand(0, 45, 2, 8'hFE);
    rd(8'h18, d, av, aid, irq); chk("R9 highest none", d, 1023);
  endtask

  task automatic t_gate;
    logic ev; logic [9:0] eid;
    set_cand(1, 40, 3, 8'hF0); chk("R2 equal mask", irq_o, 0);
    set_cand(1, 40, 3, 8'hF1); chk("R2 above mask", irq_o, 0);
    set_cand(1, 40, 3, 8'h80); chk("R2 qualifies", irq_o, 1);
    wr(8'h00, 32'h0, ev, eid); chk("R2 disabled", irq_o, 0);
    wr(8'h00, 32'h1, ev, eid); chk("R2 reenabled", irq_o, 1);
  endtask

  task automatic t_ack;
    logic [31:0] d; logic av, irq; logic [9:0] aid;
    rd(8'h0C, d, av, aid, irq);
    chk("R3 ack word", d, word(3, 40));
    chk("R3 act pulse", av, 1); chk("R3 act id", aid, 40);
    chk("R5 irq low on ack", irq, 0);
    rd(8'h14, d, av, aid, irq); chk("R3 run", d, 32'h80);
    chk("R2 equal run", irq_o, 0);
    rd(8'h0C, d, av, aid, irq); chk("R4 ack spurious", d, 1023); chk("R4 no act", av, 0);
    rd(8'h14, d, av, aid, irq); chk("R4 run kept", d, 32'h80);
  endtask

  task automatic t_nest;
    logic [31:0] d; logic av, irq, ev; logic [9:0] aid, eid;
    set_cand(1, 50, 0, 8'h40); chk("R2 preempt", irq_o, 1);
    rd(8'h0C, d, av, aid, irq); chk("R3 nested ack", d, word(0, 50));
    rd(8'h14, d, av, aid, irq); chk("R3 nested run", d, 32'h40);
    set_cand(0, 0, 0, 8'hFF);
    wr(8'h10, 32'd50, ev, eid); chk("R6 eoi pulse", ev, 1); chk("R6 eoi id", eid, 50);
    rd(8'h14, d, av, aid, irq); chk("R6 restore outer", d, 32'h80);
    wr(8'h10, 32'd40, ev, eid); chk("R6 eoi outer", ev, 1);
    rd(8'h14, d, av, aid, irq); chk("R6 restore idle", d, 32'hFF);
  endtask

  task automatic t_eoi_ignored;
    logic [31:0] d; logic av, irq, ev; logic [9:0] aid, eid;
    wr(8'h10, 32'd33, ev, eid); chk("R7 empty eoi", ev, 0);
    rd(8'h14, d, av, aid, irq); chk("R7 run idle", d, 32'hFF);
    set_cand(1, 33, 1, 8'h90);
    rd(8'h0C, d, av, aid, irq); chk("R3 ack 33", av, 1);
    set_cand(0, 0, 0, 8'hFF);
    wr(8'h10, 32'd1023, ev, eid); chk("R7 spurious eoi", ev, 0);
    rd(8'h14, d, av, aid, irq); chk("R7 run kept", d, 32'h90);
    wr(8'h10, 32'd33, ev, eid); chk("R6 eoi 33", ev, 1);
    rd(8'h14, d, av, aid, irq); chk("R6 idle", d, 32'hFF);
  endtask

  task automatic t_full;
    logic [31:0] d; logic av, irq, ev; logic [9:0] aid, eid;
    for (int k = 0; k < 4; k++) begin
      set_cand(1, 100 + k, 0, 8'h70 - 8'(k * 16));
      rd(8'h0C, d, av, aid, irq); chk("R8 fill", av, 1);
    end
    set_cand(1, 60, 0, 8'h30); chk("R8 full blocks irq", irq_o, 0);
    rd(8'h0C, d, av, aid, irq); chk("R8 full spurious", d, 1023); chk("R8 no act", av, 0);
    set_cand(0, 0, 0, 8'hFF);
    for (int k = 3; k >= 0; k--) begin
      wr(8'h10, 32'(100 + k), ev, eid); chk("R6 unwind", ev, 1);
    end
    rd(8'h14, d, av, aid, irq); chk("R6 unwound idle", d, 32'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_gate();
    t_ack();
    t_nest();
    t_eoi_ignored();
    t_full();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule